// File: doc/BRIEF.md
# Monochrome VGA Scan-Out Engine

This block produces standard 640x480 VGA raster timing from a 25 MHz pixel clock and turns a packed one-bit-per-pixel line buffer into a serial video signal. It drives active-low horizontal and vertical sync, reports the current line number, and raises a pixel-window strobe that is high only while visible pixels are being emitted. The pixel shifter is gated by that window strobe, not by the end of the sync pulse. Stored lines therefore hold exactly the visible pixels and carry no padding for the porch.

The line buffer is external and is reached through a byte read port. The block presents an address and expects the addressed byte one clock later. Each visible line takes 80 bytes, shifted out most significant bit first. A one-cycle line-start pulse at the beginning of each visible line tells the surrounding logic when to refill the buffer for that line. Fetches run two clocks ahead of the shifter, so the byte boundaries never stall.

Top module: `vga_mono_scanout`

## Requirements
- R1: Synchronous reset (`rst` high) sets `hsync_n`=1, `vsync_n`=1, `pixel`=0, `pix_window`=0, `line_start`=0, `rd_addr`=0 and `line_num`=V_TOTAL-1 (524 by default). The first clock after reset is released begins column 0 of line 0.
- R2: Every line lasts 800 clocks. `hsync_n` is low in columns 0 to 95 and high in every other column.
- R3: `line_num` advances by one in column 0 of each line and wraps from V_TOTAL-1 to 0. At default settings a frame is 525 lines.
- R4: `vsync_n` is low exactly on lines V_ACTIVE+V_FRONT and the line after it (490 and 491 by default) and high on all other lines. It changes only in the cycle in which `hsync_n` falls.
- R5: `pix_window` is high exactly in columns 144 to 783 of lines 0 to V_ACTIVE-1. `pixel` is 0 whenever `pix_window` is low, which covers sync, both porches and blank lines.
- R6: In column 144+c of a visible line, `pixel` equals bit 7-(c mod 8) of line-buffer byte c/8. Bits go out most significant first, and the line is contiguous over 80 bytes with no gap at byte boundaries.
- R7: The line buffer is read synchronously, with `rd_data` returning the byte that `rd_addr` held in the previous cycle. On a visible line `rd_addr` holds byte n during columns 142+8n to 149+8n. In every other cycle it is 0, so each line's fetch starts from address 0. It never exceeds 79.
- R8: `line_start` is high for exactly one cycle, in column 0 of each visible line (0 to V_ACTIVE-1). It is never high on blank lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | output | 7 | Byte address into the line buffer |
| rd_data | input | 8 | Byte returned by the line buffer one clock after its address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pixel | output | 1 | Serial monochrome pixel |
| pix_window | output | 1 | High only while visible pixels are emitted |
| line_start | output | 1 | One-cycle pulse at the start of each visible line |
| line_num | output | 10 | Current line number |

## Verification
Every output is registered from the next raster position, so sync, window, line number, line-start and address all change in the same cycle in which the position counter reaches the relevant column. None of them lags by a cycle. The pixel for byte n depends on two earlier events: the address placed on `rd_addr` two cycles before column 144+8n, and the one-cycle read latency of the buffer. The bench therefore keeps its own raster position model, advanced on every rising edge, and compares all outputs on the falling edge of the same cycle. Its memory model refreshes the line contents on the `line_start` pulse, well before the first fetch at column 142.

// File: rtl/vga_scan_pkg.sv
`timescale 1ns/1ps
package vga_scan_pkg;

    // Default raster: 640x480 at a 25 MHz pixel clock
    localparam int DEF_H_ACTIVE = 640;
    localparam int DEF_H_FRONT  = 16;
    localparam int DEF_H_SYNC   = 96;
    localparam int DEF_H_BACK   = 48;
    localparam int DEF_V_ACTIVE = 480;
    localparam int DEF_V_FRONT  = 10;
    localparam int DEF_V_SYNC   = 2;
    localparam int DEF_V_BACK   = 33;
    localparam int DEF_WORD_W   = 8;

    // Address runs this many clocks ahead of the pixel it feeds:
    // one clock of memory latency, one clock of shifter load.
    localparam int FETCH_LEAD = 2;

    // Position inside a line, in scan order
    typedef enum logic [1:0] {
        REG_SYNC   = 2'd0,
        REG_BACK   = 2'd1,
        REG_ACTIVE = 2'd2,
        REG_FRONT  = 2'd3
    } hreg_e;

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vga_hv_timing.sv
`timescale 1ns/1ps
module vga_hv_timing import vga_scan_pkg::*; #(
    parameter  int H_ACTIVE   = DEF_H_ACTIVE,
    parameter  int H_FRONT    = DEF_H_FRONT,
    parameter  int H_SYNC     = DEF_H_SYNC,
    parameter  int H_BACK     = DEF_H_BACK,
    parameter  int V_ACTIVE   = DEF_V_ACTIVE,
    parameter  int V_FRONT    = DEF_V_FRONT,
    parameter  int V_SYNC     = DEF_V_SYNC,
    parameter  int V_BACK     = DEF_V_BACK,
    parameter  int LSTART_COL = 0,
    localparam int H_TOTAL    = H_SYNC + H_BACK + H_ACTIVE + H_FRONT,
    localparam int V_TOTAL    = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW         = cnt_width(H_TOTAL),
    localparam int VW         = cnt_width(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] h_next,
    output logic          vis_next,
    output logic          win_next,
    output logic [VW-1:0] line_q,
    output logic          hsync_n_q,
    output logic          vsync_n_q,
    output logic          win_q,
    output logic          lstart_q
);

    localparam int ACT_BEG  = H_SYNC + H_BACK;
    localparam int ACT_END  = ACT_BEG + H_ACTIVE;
    localparam int VS_BEG   = V_ACTIVE + V_FRONT;
    localparam int VS_END   = VS_BEG + V_SYNC;

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          hs_n;
        logic          vs_n;
        logic          win;
        logic          lstart;
    } tstate_t;

    localparam tstate_t RST_STATE = '{
        h:      HW'(H_TOTAL - 1),
        v:      VW'(V_TOTAL - 1),
        hs_n:   1'b1,
        vs_n:   1'b1,
        win:    1'b0,
        lstart: 1'b0
    };

    tstate_t st_q, st_d;
    hreg_e   reg_d;
    logic    vis_d;
    logic    wrap_h;

    always_comb begin
        st_d   = st_q;
        wrap_h = (st_q.h == HW'(H_TOTAL - 1));

        // Raster position advance
        if (wrap_h) begin
            st_d.h = '0;
            if (st_q.v == VW'(V_TOTAL - 1)) begin
                st_d.v = '0;
            end else begin
                st_d.v = st_q.v + VW'(1);
            end
        end else begin
            st_d.h = st_q.h + HW'(1);
        end

        // Horizontal region of the coming position
        if (st_d.h < HW'(H_SYNC)) begin
            reg_d = REG_SYNC;
        end else if (st_d.h < HW'(ACT_BEG)) begin
            reg_d = REG_BACK;
        end else if (st_d.h < HW'(ACT_END)) begin
            reg_d = REG_ACTIVE;
        end else begin
            reg_d = REG_FRONT;
        end

        vis_d = (st_d.v < VW'(V_ACTIVE));

        // Outputs are decoded from the next position so that they
        // line up with the counter register once clocked.
        st_d.hs_n   = (reg_d != REG_SYNC);
        st_d.vs_n   = !((st_d.v >= VW'(VS_BEG)) && (st_d.v < VW'(VS_END)));
        st_d.win    = vis_d && (reg_d == REG_ACTIVE);
        st_d.lstart = vis_d && (st_d.h == HW'(LSTART_COL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_next    = st_d.h;
    assign vis_next  = vis_d;
    assign win_next  = st_d.win;
    assign line_q    = st_q.v;
    assign hsync_n_q = st_q.hs_n;
    assign vsync_n_q = st_q.vs_n;
    assign win_q     = st_q.win;
    assign lstart_q  = st_q.lstart;

endmodule

// File: rtl/vga_line_fetch.sv
`timescale 1ns/1ps
module vga_line_fetch import vga_scan_pkg::*; #(
    parameter  int H_ACTIVE = DEF_H_ACTIVE,
    parameter  int H_FRONT  = DEF_H_FRONT,
    parameter  int H_SYNC   = DEF_H_SYNC,
    parameter  int H_BACK   = DEF_H_BACK,
    parameter  int WORD_W   = DEF_WORD_W,
    localparam int H_TOTAL  = H_SYNC + H_BACK + H_ACTIVE + H_FRONT,
    localparam int HW       = cnt_width(H_TOTAL),
    localparam int AW       = cnt_width(H_ACTIVE / WORD_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] h_next,
    input  logic          vis_next,
    output logic [AW-1:0] rd_addr
);

    localparam int LW        = $clog2(WORD_W);
    localparam int LOOK_BEG  = H_SYNC + H_BACK - FETCH_LEAD;
    localparam int LOOK_END  = LOOK_BEG + H_ACTIVE;

    typedef struct packed {
        logic [AW-1:0] addr;
    } fstate_t;

    fstate_t       st_q, st_d;
    logic [HW:0]   look_col;
    logic          in_fetch;

    always_comb begin
        st_d     = st_q;
        look_col = {1'b0, h_next} - (HW + 1)'(LOOK_BEG);
        in_fetch = vis_next
                && (h_next >= HW'(LOOK_BEG))
                && (h_next <  HW'(LOOK_END));
        if (in_fetch) begin
            st_d.addr = AW'(look_col >> LW);
        end else begin
            // Parked at zero: every line's fetch begins from the first byte
            st_d.addr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.addr;

endmodule

// File: rtl/vga_pix_shift.sv
`timescale 1ns/1ps
module vga_pix_shift import vga_scan_pkg::*; #(
    parameter  int H_ACTIVE = DEF_H_ACTIVE,
    parameter  int H_FRONT  = DEF_H_FRONT,
    parameter  int H_SYNC   = DEF_H_SYNC,
    parameter  int H_BACK   = DEF_H_BACK,
    parameter  int WORD_W   = DEF_WORD_W,
    localparam int H_TOTAL  = H_SYNC + H_BACK + H_ACTIVE + H_FRONT,
    localparam int HW       = cnt_width(H_TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HW-1:0]     h_next,
    input  logic              win_next,
    input  logic [WORD_W-1:0] rd_data,
    output logic              pixel
);

    localparam int LW      = $clog2(WORD_W);
    localparam int ACT_BEG = H_SYNC + H_BACK;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic              pix;
    } sstate_t;

    sstate_t       st_q, st_d;
    logic [LW-1:0] phase;

    always_comb begin
        st_d  = st_q;
        phase = LW'(h_next - HW'(ACT_BEG));
        if (win_next) begin
            if (phase == '0) begin
                // First pixel of a new unit comes straight from the read port
                st_d.pix = rd_data[WORD_W-1];
                st_d.sh  = rd_data << 1;
            end else begin
                st_d.pix = st_q.sh[WORD_W-1];
                st_d.sh  = st_q.sh << 1;
            end
        end else begin
            st_d.pix = 1'b0;
            st_d.sh  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pixel = st_q.pix;

endmodule

// File: rtl/vga_mono_scanout.sv
`timescale 1ns/1ps
module vga_mono_scanout import vga_scan_pkg::*; #(
    parameter  int H_ACTIVE   = DEF_H_ACTIVE,
    parameter  int H_FRONT    = DEF_H_FRONT,
    parameter  int H_SYNC     = DEF_H_SYNC,
    parameter  int H_BACK     = DEF_H_BACK,
    parameter  int V_ACTIVE   = DEF_V_ACTIVE,
    parameter  int V_FRONT    = DEF_V_FRONT,
    parameter  int V_SYNC     = DEF_V_SYNC,
    parameter  int V_BACK     = DEF_V_BACK,
    parameter  int WORD_W     = DEF_WORD_W,
    parameter  int LSTART_COL = 0,
    localparam int H_TOTAL    = H_SYNC + H_BACK + H_ACTIVE + H_FRONT,
    localparam int V_TOTAL    = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW         = cnt_width(H_TOTAL),
    localparam int VW         = cnt_width(V_TOTAL),
    localparam int AW         = cnt_width(H_ACTIVE / WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              pixel,
    output logic              pix_window,
    output logic              line_start,
    output logic [VW-1:0]     line_num
);

    logic [HW-1:0] h_next;
    logic          vis_next;
    logic          win_next;

    vga_hv_timing #(
        .H_ACTIVE   (H_ACTIVE),
        .H_FRONT    (H_FRONT),
        .H_SYNC     (H_SYNC),
        .H_BACK     (H_BACK),
        .V_ACTIVE   (V_ACTIVE),
        .V_FRONT    (V_FRONT),
        .V_SYNC     (V_SYNC),
        .V_BACK     (V_BACK),
        .LSTART_COL (LSTART_COL)
    ) timing_i (
        .clk       (clk),
        .rst       (rst),
        .h_next    (h_next),
        .vis_next  (vis_next),
        .win_next  (win_next),
        .line_q    (line_num),
        .hsync_n_q (hsync_n),
        .vsync_n_q (vsync_n),
        .win_q     (pix_window),
        .lstart_q  (line_start)
    );

    vga_line_fetch #(
        .H_ACTIVE (H_ACTIVE),
        .H_FRONT  (H_FRONT),
        .H_SYNC   (H_SYNC),
        .H_BACK   (H_BACK),
        .WORD_W   (WORD_W)
    ) fetch_i (
        .clk      (clk),
        .rst      (rst),
        .h_next   (h_next),
        .vis_next (vis_next),
        .rd_addr  (rd_addr)
    );

    vga_pix_shift #(
        .H_ACTIVE (H_ACTIVE),
        .H_FRONT  (H_FRONT),
        .H_SYNC   (H_SYNC),
        .H_BACK   (H_BACK),
        .WORD_W   (WORD_W)
    ) shift_i (
        .clk      (clk),
        .rst      (rst),
        .h_next   (h_next),
        .win_next (win_next),
        .rd_data  (rd_data),
        .pixel    (pixel)
    );

endmodule

// File: rtl/vga_scanout_chk.sv
`timescale 1ns/1ps
module vga_scanout_chk import vga_scan_pkg::*; #(
    parameter  int H_ACTIVE = DEF_H_ACTIVE,
    parameter  int H_FRONT  = DEF_H_FRONT,
    parameter  int H_SYNC   = DEF_H_SYNC,
    parameter  int H_BACK   = DEF_H_BACK,
    parameter  int V_ACTIVE = DEF_V_ACTIVE,
    parameter  int V_FRONT  = DEF_V_FRONT,
    parameter  int V_SYNC   = DEF_V_SYNC,
    parameter  int V_BACK   = DEF_V_BACK,
    parameter  int WORD_W   = DEF_WORD_W,
    localparam int H_TOTAL  = H_SYNC + H_BACK + H_ACTIVE + H_FRONT,
    localparam int V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int VW       = cnt_width(V_TOTAL),
    localparam int AW       = cnt_width(H_ACTIVE / WORD_W),
    localparam int CW       = cnt_width(H_TOTAL) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] rd_addr,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          pixel,
    input logic          pix_window,
    input logic          line_start,
    input logic [VW-1:0] line_num
);

    logic [CW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
        end else if (!hsync_n) begin
            lo_cnt <= lo_cnt + CW'(1);
        end else begin
            lo_cnt <= '0;
        end
    end

    assert_hsync_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> (lo_cnt == CW'(H_SYNC)));

    assert_line_step_R3: assert property (@(posedge clk) disable iff (rst)
        (line_num != $past(line_num)) |->
            ((line_num == $past(line_num) + VW'(1)) || (line_num == '0)));

    assert_line_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        ((line_num == '0) && ($past(line_num) != '0)) |->
            ($past(line_num) == VW'(V_TOTAL - 1)));

    assert_vsync_start_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> (line_num == VW'(V_ACTIVE + V_FRONT)));

    assert_vsync_edge_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(vsync_n) |-> $fell(hsync_n));

    assert_pixel_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !pix_window |-> !pixel);

    assert_window_place_R5: assert property (@(posedge clk) disable iff (rst)
        pix_window |-> (hsync_n && (line_num < VW'(V_ACTIVE))));

    assert_addr_range_R7: assert property (@(posedge clk) disable iff (rst)
        rd_addr < AW'(H_ACTIVE / WORD_W));

    assert_lstart_visible_R8: assert property (@(posedge clk) disable iff (rst)
        line_start |-> ((line_num < VW'(V_ACTIVE)) && !pix_window));

    assert_lstart_single_R8: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);

endmodule

bind vga_mono_scanout vga_scanout_chk #(
    .H_ACTIVE (H_ACTIVE),
    .H_FRONT  (H_FRONT),
    .H_SYNC   (H_SYNC),
    .H_BACK   (H_BACK),
    .V_ACTIVE (V_ACTIVE),
    .V_FRONT  (V_FRONT),
    .V_SYNC   (V_SYNC),
    .V_BACK   (V_BACK),
    .WORD_W   (WORD_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_addr    (rd_addr),
    .hsync_n    (hsync_n),
    .vsync_n    (vsync_n),
    .pixel      (pixel),
    .pix_window (pix_window),
    .line_start (line_start),
    .line_num   (line_num)
);

// File: tb/vga_mono_scanout_tb_top.sv
`timescale 1ns/1ps
module vga_mono_scanout_tb_top;

    // Horizontal timing at defaults; vertical shortened to keep frames short
    localparam int HA  = 640;
    localparam int HF  = 16;
    localparam int HS  = 96;
    localparam int HB  = 48;
    localparam int VA  = 6;
    localparam int VF  = 2;
    localparam int VS  = 2;
    localparam int VB  = 3;
    localparam int WW  = 8;
    localparam int HT  = HS + HB + HA + HF;
    localparam int VT  = VA + VF + VS + VB;
    localparam int HST = HS + HB;
    localparam int NB  = HA / WW;
    localparam int AW  = 7;
    localparam int VW  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] rd_addr;
    logic [WW-1:0] rd_data = '0;
    logic          hsync_n, vsync_n, pixel, pix_window, line_start;
    logic [VW-1:0] line_num;

    always #2.5 clk = ~clk;

    vga_mono_scanout #(
        .H_ACTIVE (HA), .H_FRONT (HF), .H_SYNC (HS), .H_BACK (HB),
        .V_ACTIVE (VA), .V_FRONT (VF), .V_SYNC (VS), .V_BACK (VB),
        .WORD_W   (WW), .LSTART_COL (0)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .hsync_n    (hsync_n),
        .vsync_n    (vsync_n),
        .pixel      (pixel),
        .pix_window (pix_window),
        .line_start (line_start),
        .line_num   (line_num)
    );

    int n_checks = 0;
    int n_err    = 0;
    int pat_sel  = 0;
    int mh       = HT - 1;
    int mv       = VT - 1;

    logic [WW-1:0] mem [NB];

    // Bench position model: column and line of the current cycle
    always @(posedge clk) begin
        if (rst) begin
            mh <= HT - 1;
            mv <= VT - 1;
        end else if (mh == HT - 1) begin
            mh <= 0;
            mv <= (mv == VT - 1) ? 0 : mv + 1;
        end else begin
            mh <= mh + 1;
        end
    end

    function automatic logic [WW-1:0] pattern(input int sel, input int line, input int n);
        case (sel)
            0: return WW'(n * 29 + line * 7 + 60);
            1: begin
                if (n == 0)       return 8'h80;
                else if (n == NB - 1) return 8'h01;
                else              return (line % 2 == 1) ? 8'hFF : 8'h00;
            end
            default: return 8'hAA ^ WW'(n) ^ WW'(line << 4);
        endcase
    endfunction

    // Synchronous line buffer, one clock of read latency
    always @(posedge clk) rd_data <= mem[rd_addr];

    // Refill the buffer for the line being announced
    always @(negedge clk) begin
        if (line_start) begin
            for (int n = 0; n < NB; n++) mem[n] <= pattern(pat_sel, int'(line_num), n);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s col=%0d line=%0d actual=%0d expected=%0d", req, mh, mv, act, exp);
        end
    endtask

    // One cycle, all outputs compared against the position model
    task automatic cyc_check();
        int  c;
        int  ex_addr;
        int  ex_pix;
        bit  ex_win;
        @(negedge clk);
        ex_win  = (mv < VA) && (mh >= HST) && (mh < HST + HA);
        ex_pix  = 0;
        if (ex_win) begin
            c = mh - HST;
            ex_pix = int'(mem[c / WW][WW - 1 - (c % WW)]);
        end
        ex_addr = 0;
        if ((mv < VA) && (mh >= HST - 2) && (mh < HST + HA - 2)) ex_addr = (mh - (HST - 2)) / WW;
        check("R2", int'(hsync_n), (mh >= HS) ? 1 : 0);
        check("R3", int'(line_num), mv);
        check("R4", int'(vsync_n), ((mv >= VA + VF) && (mv < VA + VF + VS)) ? 0 : 1);
        check("R5", int'(pix_window), ex_win ? 1 : 0);
        check("R6", int'(pixel), ex_pix);
        check("R7", int'(rd_addr), ex_addr);
        check("R8", int'(line_start), ((mh == 0) && (mv < VA)) ? 1 : 0);
    endtask

    task automatic check_reset_outputs();
        check("R1 hsync_n", int'(hsync_n), 1);
        check("R1 vsync_n", int'(vsync_n), 1);
        check("R1 pixel", int'(pixel), 0);
        check("R1 pix_window", int'(pix_window), 0);
        check("R1 line_start", int'(line_start), 0);
        check("R1 rd_addr", int'(rd_addr), 0);
        check("R1 line_num", int'(line_num), VT - 1);
    endtask

    // R1: state held in reset, then first line after release
    task automatic t_reset_state();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_reset_outputs();
        rst = 1'b0;
        cyc_check();
        check("R1 first col hsync", int'(hsync_n), 0);
        check("R1 first line", int'(line_num), 0);
        check("R1 first line_start", int'(line_start), 1);
    endtask

    // R2..R8 over whole lines with a chosen buffer pattern
    task automatic t_run_lines(input int nlines, input int sel);
        pat_sel = sel;
        repeat (nlines * HT) cyc_check();
    endtask

    // R3/R4: run across the frame wrap and check line 0 follows the last line
    task automatic t_frame_wrap();
        int guard = 0;
        while (!((mv == VT - 1) && (mh == HT - 1)) && guard < VT * HT) begin
            cyc_check();
            guard++;
        end
        cyc_check();
        check("R3 wrap line", int'(line_num), 0);
        check("R4 vsync after wrap", int'(vsync_n), 1);
    endtask

    // R1: reset applied in mid line restarts the raster
    task automatic t_mid_reset();
        int guard = 0;
        while (!((mv == 3) && (mh == 400)) && guard < 2 * VT * HT) begin
            cyc_check();
            guard++;
        end
        rst = 1'b1;
        repeat (3) cyc_check();
        check_reset_outputs();
        rst = 1'b0;
        cyc_check();
        check("R1 restart line", int'(line_num), 0);
        check("R1 restart hsync", int'(hsync_n), 0);
        t_run_lines(2, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_run_lines(VT, 0);
        t_run_lines(VT, 1);
        t_frame_wrap();
        t_mid_reset();
        t_run_lines(VT, 2);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule